// File: doc/BRIEF.md
# Unlockable Indirect Test-Register Window

This block is the register-side end of a PHY management register file. It claims three entries of the 32-entry management register space: a command word at address 20, a read-back word at address 21 and a staging word at address 23. Through these three entries software reaches four hidden banks of 32 internal 16-bit registers. Bank 0 holds analog/DSP tuning, bank 1 holds wake-on-LAN state, bank 2 is not implemented, and bank 3 holds self-test and clock-synthesizer settings.

The hidden banks are locked after reset. Software arms them with a fixed handshake of four command-word writes. While the banks are open, one command-word write either fetches a bank register into the read-back word or commits the staging word into a bank register. Writing zero to the command word shuts the banks again.

The port is a plain synchronous register interface of the kind found behind a serial management front end. It has an address, write data, write and read strobes, and a registered read-data output. Bank 1 entry 0x0C, a link-validity status word, and bank 3 entry 0x1B, the synthesizer control word, take their reset values from parameters. Every other hidden register resets to zero.

Top module: `phy_tst_unit`

## Requirements
- R1: A read strobe at address A puts the value of A on `reg_rdata` after the next clock edge, and `reg_rdata` holds when no read is strobed. Address 20 returns the last word written there. Address 21 returns the read-back word. Address 23 returns the staging word. Every other address reads as 0, and writes to it are dropped. Writes to address 21 have no effect.
- R2: The banks open only after four consecutive writes to address 20 with the values 0x0000, 0x0400, 0x0000, 0x0400. A value that does not fit the next step restarts the handshake. A restarting 0x0000 counts as its first step.
- R3: While the banks are open, writing 0x0000 to address 20 closes them, and any later command is ignored until the handshake is repeated.
- R4: Command word fields: bit 15 requests a read, bit 14 requests a write, bits 12:11 pick the bank, bit 10 is the test-mode flag, bits 9:5 give the read index and bits 4:0 give the write index. An open read command loads the addressed bank register into the read-back word on the same edge that accepts the command.
- R5: An open write command copies the staging word (address 23) into the addressed bank register. A later read command returns that value.
- R6: A command with both bit 15 and bit 14 set performs only the read. The bank register targeted by the write index keeps its value.
- R7: Bank 2 always reads as 0, and writes to it are discarded.
- R8: Read and write commands issued while the banks are locked leave the read-back word and every bank register unchanged.
- R9: After reset the banks are locked and every register reads 0. The exceptions are bank 1 entry 0x0C, which takes parameter `STAT_RST`, and bank 3 entry 0x1B, which takes parameter `PLL_RST`.
- R10: While the banks are open, a command word with bit 10 clear performs no access and leaves the banks open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Management register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |

## Verification
A write to address 20 or 23 takes effect on the edge that samples the strobe. This applies to a handshake step, a read-back load or a bank commit. Any read strobed in the next cycle therefore already sees the new value. `reg_rdata` is loaded on the edge that samples `reg_rd`, which gives a one-cycle read latency. The bench drives strobes just after a falling edge. Its behavioural model applies each strobe on the rising edge that the design samples. On the falling edge that follows, the bench compares `reg_rdata` with the model's value. Directed reads with hard-coded expected values land in that same sample slot.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

  localparam int DW        = 16;
  localparam int MII_AW    = 5;
  localparam int BANK_AW   = 5;
  localparam int NBANK     = 4;
  localparam int BSEL_W    = $clog2(NBANK);

  localparam logic [MII_AW-1:0] A_CMD   = MII_AW'(20);
  localparam logic [MII_AW-1:0] A_RBACK = MII_AW'(21);
  localparam logic [MII_AW-1:0] A_STAGE = MII_AW'(23);

  localparam int B_RD  = 15;
  localparam int B_WR  = 14;
  localparam int B_BHI = 12;
  localparam int B_BLO = 11;
  localparam int B_TM  = 10;
  localparam int B_RHI = 9;
  localparam int B_RLO = 5;
  localparam int B_WHI = 4;
  localparam int B_WLO = 0;

  localparam logic [DW-1:0] KEY_ARM  = DW'(1) << B_TM;
  localparam logic [DW-1:0] KEY_ZERO = '0;

  typedef enum logic [2:0] {
    UL_IDLE,
    UL_Z1,
    UL_T1,
    UL_Z2,
    UL_OPEN
  } unlock_e;

  typedef struct packed {
    logic                rd;
    logic                wr;
    logic [BSEL_W-1:0]   bank;
    logic                tm;
    logic [BANK_AW-1:0]  ridx;
    logic [BANK_AW-1:0]  widx;
  } cmd_t;

  function automatic cmd_t split_cmd(input logic [DW-1:0] w);
    cmd_t c;
    c.rd   = w[B_RD];
    c.wr   = w[B_WR];
    c.bank = w[B_BHI:B_BLO];
    c.tm   = w[B_TM];
    c.ridx = w[B_RHI:B_RLO];
    c.widx = w[B_WHI:B_WLO];
    return c;
  endfunction

endpackage

// File: rtl/phy_tst_unlock.sv
module phy_tst_unlock
  import phy_tst_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_word,
  output logic          is_open
);

  unlock_e st_q, st_d;
  logic    is_zero, is_arm;

  assign is_zero = (ctl_word == KEY_ZERO);
  assign is_arm  = (ctl_word == KEY_ARM);

  always_comb begin
    st_d = st_q;
    if (ctl_wr) begin
      unique case (st_q)
        UL_IDLE: st_d = is_zero ? UL_Z1 : UL_IDLE;
        UL_Z1:   st_d = is_arm  ? UL_T1 : (is_zero ? UL_Z1 : UL_IDLE);
        UL_T1:   st_d = is_zero ? UL_Z2 : UL_IDLE;
        UL_Z2:   st_d = is_arm  ? UL_OPEN : (is_zero ? UL_Z1 : UL_IDLE);
        UL_OPEN: st_d = is_zero ? UL_Z1 : UL_OPEN;
        default: st_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= UL_IDLE;
    else     st_q <= st_d;
  end

  assign is_open = (st_q == UL_OPEN);

endmodule

// File: rtl/phy_tst_bank.sv
module phy_tst_bank #(
  parameter int          DW       = 16,
  parameter int          AW       = 5,
  parameter bit          IMPL     = 1'b1,
  parameter bit          HAS_SPEC = 1'b0,
  parameter int          SPEC_IDX = 0,
  parameter logic [15:0] SPEC_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  generate
    if (IMPL) begin : g_mem
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= (HAS_SPEC && i == SPEC_IDX) ? DW'(SPEC_RST) : '0;
          end
        end else if (we) begin
          mem[widx] <= wdata;
        end
      end

      assign rdata = mem[ridx];
    end else begin : g_hole
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, we, widx, wdata, ridx};
      assign rdata     = '0;
    end
  endgenerate

endmodule

// File: rtl/phy_tst_unit.sv
module phy_tst_unit
  import phy_tst_pkg::*;
#(
  parameter logic [15:0] STAT_RST = 16'h0000,
  parameter logic [15:0] PLL_RST  = 16'h0000,
  parameter int          STAT_IDX = 12,
  parameter int          PLL_IDX  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MII_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata
);

  logic          ctl_wr, stg_wr, bank_open;
  logic          do_rd, do_wr;
  cmd_t          cmd;
  logic [DW-1:0] cmd_q, rback_q, stage_q;
  logic [DW-1:0] bank_rd [NBANK];
  logic [DW-1:0] sel_rd;

  assign ctl_wr = reg_wr && (reg_addr == A_CMD);
  assign stg_wr = reg_wr && (reg_addr == A_STAGE);
  assign cmd    = split_cmd(reg_wdata);
  assign do_rd  = ctl_wr && bank_open && cmd.tm && cmd.rd;
  assign do_wr  = ctl_wr && bank_open && cmd.tm && cmd.wr && !cmd.rd;

  phy_tst_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_word (reg_wdata),
    .is_open  (bank_open)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    phy_tst_bank #(
      .DW       (DW),
      .AW       (BANK_AW),
      .IMPL     (b != 2),
      .HAS_SPEC ((b == 1) || (b == 3)),
      .SPEC_IDX ((b == 1) ? STAT_IDX : PLL_IDX),
      .SPEC_RST ((b == 1) ? STAT_RST : PLL_RST)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (do_wr && (cmd.bank == BSEL_W'(b))),
      .widx  (cmd.widx),
      .wdata (stage_q),
      .ridx  (cmd.ridx),
      .rdata (bank_rd[b])
    );
  end

  assign sel_rd = bank_rd[cmd.bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      rback_q <= '0;
      stage_q <= '0;
    end else begin
      if (ctl_wr) cmd_q   <= reg_wdata;
      if (stg_wr) stage_q <= reg_wdata;
      if (do_rd)  rback_q <= sel_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        A_CMD:   reg_rdata <= cmd_q;
        A_RBACK: reg_rdata <= rback_q;
        A_STAGE: reg_rdata <= stage_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_tst_unit_chk.sv
module phy_tst_unit_chk
  import phy_tst_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MII_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DW-1:0]     reg_rdata,
  input logic              bank_open,
  input logic [DW-1:0]     rback_q
);

  logic cw;
  assign cw = reg_wr && (reg_addr == A_CMD);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R1

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(bank_open) |-> $past(cw && reg_wdata == KEY_ARM)); // R2

  AST_ZERO_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cw && reg_wdata == KEY_ZERO) |=> !bank_open); // R3

  AST_LOCKED_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cw && !bank_open) |=> $stable(rback_q)); // R8

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cw && bank_open && reg_wdata[B_RD] && reg_wdata[B_TM] &&
     reg_wdata[B_BHI:B_BLO] == 2'd2) |=> (rback_q == '0)); // R7

endmodule

bind phy_tst_unit phy_tst_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .bank_open (bank_open),
  .rback_q   (rback_q)
);

// File: tb/phy_tst_unit_tb.sv
module phy_tst_unit_tb;

  localparam logic [15:0] STAT_V = 16'h1000;
  localparam logic [15:0] PLL_V  = 16'h0005;
  localparam logic [15:0] TM     = 16'h0400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  phy_tst_unit #(.STAT_RST(STAT_V), .PLL_RST(PLL_V)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  int m_bk [4][32];
  int m_st, m_cmd, m_rb, m_stage, m_out;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_bk[b, i]) m_bk[b][i] = 0;
      m_bk[1][12] = STAT_V;
      m_bk[3][27] = PLL_V;
      m_st = 0; m_cmd = 0; m_rb = 0; m_stage = 0; m_out = 0;
    end else begin
      if (reg_rd)
        m_out = (reg_addr == 20) ? m_cmd : (reg_addr == 21) ? m_rb :
                (reg_addr == 23) ? m_stage : 0;
      if (reg_wr && reg_addr == 23) m_stage = reg_wdata;
      if (reg_wr && reg_addr == 20) begin
        int w, bk;
        w  = reg_wdata;
        bk = (w >> 11) & 3;
        m_cmd = w;
        if (m_st == 4 && w[10]) begin
          if (w[15]) m_rb = (bk == 2) ? 0 : m_bk[bk][(w >> 5) & 31];
          else if (w[14] && bk != 2) m_bk[bk][w & 31] = m_stage;
        end
        if (m_st == 4) m_st = (w == 0) ? 1 : 4;
        else if (w == (((m_st == 0) || (m_st == 2)) ? 0 : int'(TM))) m_st = m_st + 1;
        else m_st = (w == 0) ? 1 : 0;
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison with the model (read port timing, R1)
  always @(negedge clk) if (!rst && !done) chk("R1", reg_rdata, 16'(m_out));

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] e, input string req);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, reg_rdata, e);
  endtask

  task automatic unlock();
    wr(20, 0); wr(20, TM); wr(20, 0); wr(20, TM);
  endtask

  function automatic logic [15:0] rcmd(input int b, input int i);
    return 16'h8000 | 16'(b << 11) | TM | 16'(i << 5);
  endfunction

  function automatic logic [15:0] wcmd(input int b, input int i);
    return 16'h4000 | 16'(b << 11) | TM | 16'(i);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    rd_exp(21, 16'h0000, "R9");
    rd_exp(20, 16'h0000, "R9");
    wr(20, rcmd(1, 12)); rd_exp(21, 16'h0000, "R8");
    unlock();
    wr(20, rcmd(1, 12)); rd_exp(21, STAT_V, "R9");
    wr(20, rcmd(3, 27)); rd_exp(21, PLL_V, "R9");
    wr(20, rcmd(0, 3));  rd_exp(21, 16'h0000, "R4");
    // R5 write then read back
    wr(23, 16'hA5A5); rd_exp(23, 16'hA5A5, "R1");
    wr(20, wcmd(0, 9)); wr(20, rcmd(0, 9)); rd_exp(21, 16'hA5A5, "R5");
    wr(23, 16'h029A); wr(20, wcmd(3, 29)); wr(20, rcmd(3, 29));
    rd_exp(21, 16'h029A, "R4");
    // R6 read wins
    wr(23, 16'h1234); wr(20, rcmd(0, 9) | 16'h4000 | 16'd9);
    rd_exp(21, 16'hA5A5, "R6");
    wr(20, rcmd(3, 29)); wr(20, rcmd(0, 9)); rd_exp(21, 16'hA5A5, "R6");
    // R7 hole bank
    wr(23, 16'hFFFF); wr(20, wcmd(2, 4)); wr(20, rcmd(2, 4));
    rd_exp(21, 16'h0000, "R7");
    // R10 no test-mode flag
    wr(20, rcmd(1, 12) & ~TM); rd_exp(21, 16'h0000, "R10");
    wr(20, rcmd(1, 12)); rd_exp(21, STAT_V, "R10");
    // R3 close
    wr(20, 0); wr(20, rcmd(0, 9)); rd_exp(21, STAT_V, "R3");
    // R2 broken handshake
    wr(20, 0); wr(20, TM); wr(20, TM); wr(20, 0); wr(20, TM);
    wr(20, rcmd(0, 9)); rd_exp(21, STAT_V, "R2");
    // R8 locked write
    wr(23, 16'h7777); wr(20, wcmd(0, 9));
    // R2 restart with doubled zero
    wr(20, 0); wr(20, 0); wr(20, TM); wr(20, 0); wr(20, TM);
    wr(20, rcmd(0, 9)); rd_exp(21, 16'hA5A5, "R8");
    wr(20, rcmd(3, 27)); rd_exp(21, PLL_V, "R2");
    // R1 map edges
    wr(7, 16'hFFFF); rd_exp(7, 16'h0000, "R1");
    wr(21, 16'hBEEF); rd_exp(21, PLL_V, "R1");
    rd_exp(20, rcmd(3, 27), "R1");
    rd_exp(23, 16'h7777, "R1");
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule